// File: doc/BRIEF.md
# Two-Exposure HDR Pixel Compositor

This block fuses a pair of co-located RGB pixels, one from a short exposure and one from a long exposure, into a 16-bit high-dynamic-range value per colour channel. It also reduces the three fused channels to one 16-bit luminance value. For each channel, each 8-bit code is looked up in two computed tables. The first table holds a certainty weight. The second holds the product of inverse camera response and that weight. Both tables carry the same binary pre-scale, so the scale cancels in the division. A pipelined restoring divider then forms the certainty-weighted average of the two exposures.

When both exposures of a channel have zero certainty, a division is not meaningful. These are the fully black and fully clipped codes. In that case a multiplexer after the divider substitutes a fixed value in place of the quotient. The special-case flag travels through the divider beside the quotient, so it stays aligned with it.

Both edges of the block are valid/ready streams. A pixel pair is taken on a rising edge when `in_valid` and `in_ready` are both high. A result leaves on a rising edge when `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the whole pipeline freezes. During that time the outputs hold their values and `in_ready` stays low.

Top module: `hdr_compositor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: Each pixel is packed as red in bits [23:16], green in [15:8] and blue in [7:0], and each channel is processed on its own. For a code c, the weight is w(c) = c when c < 128 and 255 - c otherwise. When w(s) + w(l) is nonzero, the channel output is floor((s*s*w(s) + l*l*w(l)) / (w(s) + w(l))), where s is the short-exposure code and l is the long-exposure code.
- R3: When w(s) + w(l) = 0 and the short-exposure code is 255, the channel output is 0xFFFF.
- R4: When w(s) + w(l) = 0 and both codes are 0, the channel output is 0x0000.
- R5: When w(s) + w(l) = 0, the short-exposure code is 0 and the long-exposure code is 255, the channel output is 0x8000.
- R6: `out_luma` equals (R + 2*G + B) >> 2, computed from the channel values presented in the same output beat.
- R7: Each accepted pixel pair produces exactly one output, and outputs leave in the order the pairs were accepted. With `out_ready` held high, the result is valid right after the 18th rising edge that follows the accepting edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and in the next cycle `out_valid` and all output values are unchanged. `in_ready` is high whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel pair present |
| in_ready | output | 1 | Block can take a pixel pair this cycle |
| short_pix | input | 24 | Short-exposure RGB pixel |
| long_pix | input | 24 | Long-exposure RGB pixel |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Sink takes the output beat |
| out_r | output | 16 | Fused red value |
| out_g | output | 16 | Fused green value |
| out_b | output | 16 | Fused blue value |
| out_luma | output | 16 | Luminance of the fused channels |

## Verification
The hardest situation to reach is a stall that freezes the pipeline while results in flight carry different substitution flags in different channels. If the frozen pipeline lets a flag slip by one stage against its quotient, the wrong channel gets the substituted value. To reach this, the stimulus forces each channel code independently to 0 or 255 with high probability, so one pixel often mixes normal, clipped and black channels. At the same time it drops `out_ready` at random and inserts input gaps, so bubbles and stalls overlap inside the divider chain. Directed pairs cover each substitution value and weight pairs chosen so the quotient has to be truncated.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  parameter int CODE_W   = 8;
  parameter int CH_N     = 3;
  parameter int SCALE    = 8;
  parameter int PROD_W   = 32;
  parameter int CERT_W   = 16;
  parameter int Q_W      = 16;
  parameter int PIX_W    = CH_N * CODE_W;
  parameter int NUM_W    = PROD_W + 1;
  parameter int DEN_W    = CERT_W + 1;
  // stage A, stage B, Q_W-1 divider stages, mux stage, output stage
  parameter int PIPE_LAT = Q_W + 3;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [Q_W-1:0]    chan_t;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_MAX  = 2'd1,
    SAT_ZERO = 2'd2,
    SAT_MID  = 2'd3
  } sat_e;

  localparam code_t CODE_TOP  = '1;
  localparam int    CODE_HALF = 1 << (CODE_W - 1);

  // certainty: rises from the black code, falls toward the clipped code
  function automatic longint unsigned weight_of(code_t c);
    longint unsigned cv;
    cv = longint'(c);
    return (cv < longint'(CODE_HALF)) ? cv : longint'(CODE_TOP) - cv;
  endfunction

  // inverse response modelled as a square law
  function automatic longint unsigned resp_of(code_t c);
    longint unsigned cv;
    cv = longint'(c);
    return cv * cv;
  endfunction

  function automatic logic [CERT_W-1:0] cert_entry(code_t c);
    return CERT_W'(weight_of(c) << SCALE);
  endfunction

  function automatic logic [PROD_W-1:0] prod_entry(code_t c);
    return PROD_W'((resp_of(c) * weight_of(c)) << SCALE);
  endfunction
endpackage

// File: rtl/hdr_lut.sv
module hdr_lut
  import hdr_pkg::*;
(
  input  code_t              code,
  output logic [PROD_W-1:0]  prod,
  output logic [CERT_W-1:0]  cert
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    prod = prod_entry(code);
    cert = cert_entry(code);
  end
endmodule

// File: rtl/hdr_div_stage.sv
module hdr_div_stage #(
  parameter int NW  = 33,
  parameter int DW  = 17,
  parameter int QW  = 16,
  parameter int BIT = 0,
  parameter int SBW = 2
) (
  input  logic           clk,
  input  logic           en,
  input  logic [NW-1:0]  rem_i,
  input  logic [DW-1:0]  den_i,
  input  logic [QW-1:0]  q_i,
  input  logic [SBW-1:0] sb_i,
  output logic [NW-1:0]  rem_o,
  output logic [DW-1:0]  den_o,
  output logic [QW-1:0]  q_o,
  output logic [SBW-1:0] sb_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int XW = NW + QW;

  logic [XW-1:0] dsh;
  logic [XW-1:0] rem_x;
  logic          fits;
  logic [NW-1:0] rem_n;
  logic [QW-1:0] q_n;

  always_comb begin
    dsh   = XW'(den_i) << BIT;
    rem_x = XW'(rem_i);
    fits  = (rem_x >= dsh);
    rem_n = fits ? NW'(rem_x - dsh) : rem_i;
    q_n   = q_i;
    q_n[BIT] = fits;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      rem_o <= rem_n;
      den_o <= den_i;
      q_o   <= q_n;
      sb_o  <= sb_i;
    end
  end
endmodule

// File: rtl/hdr_channel.sv
module hdr_channel
  import hdr_pkg::*;
(
  input  logic  clk,
  input  logic  adv,
  input  code_t s_code,
  input  code_t l_code,
  output chan_t val
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SBW   = 2;
  localparam int DIV_N = Q_W - 1;

  logic [PROD_W-1:0] ps_c, pl_c;
  logic [CERT_W-1:0] cs_c, cl_c;
  sat_e              sat_c;

  hdr_lut u_lut_s (.code(s_code), .prod(ps_c), .cert(cs_c));
  hdr_lut u_lut_l (.code(l_code), .prod(pl_c), .cert(cl_c));

  always_comb begin
    sat_c = SAT_NONE;
    if (cs_c == '0 && cl_c == '0) begin
      if (s_code == CODE_TOP)      sat_c = SAT_MAX;
      else if (l_code == '0)       sat_c = SAT_ZERO;
      else                         sat_c = SAT_MID;
    end
  end

  // stage A: table outputs
  logic [PROD_W-1:0] ps_a, pl_a;
  logic [CERT_W-1:0] cs_a, cl_a;
  sat_e              sat_a;

  always_ff @(posedge clk) begin
    if (adv) begin
      ps_a  <= ps_c;
      pl_a  <= pl_c;
      cs_a  <= cs_c;
      cl_a  <= cl_c;
      sat_a <= sat_c;
    end
  end

  // stage B: numerator and denominator sums
  logic [NUM_W-1:0] num_b;
  logic [DEN_W-1:0] den_b;
  logic [SBW-1:0]   sb_b;

  always_ff @(posedge clk) begin
    if (adv) begin
      num_b <= NUM_W'(ps_a) + NUM_W'(pl_a);
      den_b <= DEN_W'(cs_a) + DEN_W'(cl_a);
      sb_b  <= sat_a;
    end
  end

  // restoring divider: one registered stage per upper quotient bit
  logic [DIV_N:0][NUM_W-1:0] rem_a;
  logic [DIV_N:0][DEN_W-1:0] den_a;
  logic [DIV_N:0][Q_W-1:0]   q_a;
  logic [DIV_N:0][SBW-1:0]   sb_a;

  assign rem_a[0] = num_b;
  assign den_a[0] = den_b;
  assign q_a[0]   = '0;
  assign sb_a[0]  = sb_b;

  for (genvar i = 0; i < DIV_N; i++) begin : g_div
    hdr_div_stage #(
      .NW(NUM_W), .DW(DEN_W), .QW(Q_W), .BIT(Q_W - 1 - i), .SBW(SBW)
    ) u_stage (
      .clk   (clk),
      .en    (adv),
      .rem_i (rem_a[i]),
      .den_i (den_a[i]),
      .q_i   (q_a[i]),
      .sb_i  (sb_a[i]),
      .rem_o (rem_a[i+1]),
      .den_o (den_a[i+1]),
      .q_o   (q_a[i+1]),
      .sb_o  (sb_a[i+1])
    );
  end

  // last quotient bit fused with the substitution multiplexer
  logic  fits0;
  chan_t q_full;
  chan_t val_n;

  always_comb begin
    fits0  = (rem_a[DIV_N] >= NUM_W'(den_a[DIV_N]));
    q_full = q_a[DIV_N] | Q_W'(fits0);
    case (sat_e'(sb_a[DIV_N]))
      SAT_MAX:  val_n = '1;
      SAT_ZERO: val_n = '0;
      SAT_MID:  val_n = chan_t'(1) << (Q_W - 1);
      default:  val_n = q_full;
    endcase
  end

  always_ff @(posedge clk) begin
    if (adv) val <= val_n;
  end
endmodule

// File: rtl/hdr_compositor.sv
module hdr_compositor
  import hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  short_pix,
  input  logic [PIX_W-1:0]  long_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [Q_W-1:0]    out_r,
  output logic [Q_W-1:0]    out_g,
  output logic [Q_W-1:0]    out_b,
  output logic [Q_W-1:0]    out_luma
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LSUM_W = Q_W + 2;

  logic                adv;
  logic [PIPE_LAT-1:0] vld;
  chan_t               vals [CH_N];

  assign out_valid = vld[PIPE_LAT-1];
  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= '0;
    else if (adv) vld <= {vld[PIPE_LAT-2:0], in_valid};
  end

  // channel 0 is red in the top byte
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    hdr_channel u_chan (
      .clk    (clk),
      .adv    (adv),
      .s_code (short_pix[PIX_W-1-ch*CODE_W -: CODE_W]),
      .l_code (long_pix[PIX_W-1-ch*CODE_W -: CODE_W]),
      .val    (vals[ch])
    );
  end

  // luminance by shift and add: R/4 + G/2 + B/4
  logic [LSUM_W-1:0] lsum;
  chan_t             luma_n;

  always_comb begin
    lsum   = LSUM_W'(vals[0]) + (LSUM_W'(vals[1]) << 1) + LSUM_W'(vals[2]);
    luma_n = chan_t'(lsum >> 2);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_r    <= vals[0];
      out_g    <= vals[1];
      out_b    <= vals[2];
      out_luma <= luma_n;
    end
  end
endmodule

// File: rtl/hdr_compositor_chk.sv
module hdr_compositor_chk
  import hdr_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [Q_W-1:0] out_r,
  input logic [Q_W-1:0] out_g,
  input logic [Q_W-1:0] out_b,
  input logic [Q_W-1:0] out_luma
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int OCC_W = $clog2(PIPE_LAT + 2) + 1;

  logic [OCC_W-1:0] occ;
  logic [Q_W-1:0]   hi, lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OCC_W'(in_valid && in_ready) - OCC_W'(out_valid && out_ready);
  end

  always_comb begin
    hi = out_r;
    lo = out_r;
    if (out_g > hi) hi = out_g;
    if (out_b > hi) hi = out_b;
    if (out_g < lo) lo = out_g;
    if (out_b < lo) lo = out_b;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_r) && $stable(out_g)
                                && $stable(out_b) && $stable(out_luma));

  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6
  luma_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_luma <= hi) && (out_luma >= lo));

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ != '0);

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(PIPE_LAT));
endmodule

bind hdr_compositor hdr_compositor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b),
  .out_luma  (out_luma)
);

// File: tb/hdr_compositor_test.sv
module hdr_compositor_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [23:0] short_pix, long_pix;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_r, out_g, out_b, out_luma;

  always #2.5 clk = ~clk;

  hdr_compositor uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .short_pix(short_pix), .long_pix(long_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_luma(out_luma)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  logic [47:0] sb_q[$];
  bit          stall_mode = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic longint wt(longint c);
    return (c < 128) ? c : 255 - c;
  endfunction

  function automatic longint chan_model(longint s, longint l, output string tag);
    longint den;
    den = wt(s) + wt(l);
    if (den == 0) begin
      if (s == 255)    begin tag = "R3"; return 64'hFFFF; end
      else if (l == 0) begin tag = "R4"; return 0; end
      else             begin tag = "R5"; return 64'h8000; end
    end
    tag = "R2";
    return (s*s*wt(s) + l*l*wt(l)) / den;
  endfunction

  task automatic pick_ready();
    if (stall_mode) out_ready = ($urandom_range(3) != 0);
    else            out_ready = 1'b1;
  endtask

  task automatic send(input logic [23:0] s, input logic [23:0] l);
    @(negedge clk);
    short_pix = s; long_pix = l; in_valid = 1'b1;
    pick_ready();
    #1;
    while (!in_ready) begin
      @(negedge clk);
      pick_ready();
      #1;
    end
    sb_q.push_back({s, l});
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    pick_ready();
  endtask

  // monitor / scoreboard
  initial begin : monitor
    bit          held = 0;
    logic [63:0] snap;
    forever begin
      @(negedge clk);
      #2;
      if (!rst_n) begin
        held = 0;
      end else begin
        if (held)
          chk(out_valid && {out_r, out_g, out_b, out_luma} == snap, "R8", "held beat",
              {out_r, out_g, out_b, out_luma}, snap);
        if (!out_valid)
          chk(in_ready, "R8", "in_ready when empty", in_ready, 1);
        if (out_valid && !out_ready) begin
          chk(!in_ready, "R8", "in_ready during stall", in_ready, 0);
          held = 1;
          snap = {out_r, out_g, out_b, out_luma};
        end else begin
          held = 0;
        end
        if (out_valid && out_ready) begin
          if (sb_q.size() == 0) begin
            chk(0, "R7", "output with nothing accepted", 1, 0);
          end else begin
            logic [47:0] item;
            longint      e[3];
            longint      got[3];
            longint      el;
            string       tg;
            item   = sb_q.pop_front();
            got[0] = out_r; got[1] = out_g; got[2] = out_b;
            for (int c = 0; c < 3; c++) begin
              e[c] = chan_model(item[47-8*c -: 8], item[23-8*c -: 8], tg);
              chk(got[c] == e[c], tg, $sformatf("channel %0d", c), got[c], e[c]);
            end
            el = (e[0] + 2*e[1] + e[2]) >> 2;
            chk(out_luma == el, "R6", "luma", out_luma, el);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin : driver
    int n;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    short_pix = '0; long_pix = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && in_ready, "R1", "reset state", {out_valid, in_ready}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R1", "after release", {out_valid, in_ready}, 2'b01);

    // R7 latency with out_ready held high
    send({8'd10, 8'd127, 8'd200}, {8'd200, 8'd128, 8'd10});
    #1 in_valid = 1'b0;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      #1;
    end while (!out_valid && n < 40);
    chk(n == 18, "R7", "latency in edges", n, 18);
    repeat (3) idle();

    // directed corner pairs
    send(24'hFFFFFF, 24'hFFFFFF);                       // R3
    send(24'h000000, 24'h000000);                       // R4
    send(24'h000000, 24'hFFFFFF);                       // R5
    send(24'hFFFFFF, 24'h000000);                       // R3
    send({8'd255, 8'd0, 8'd0}, {8'd255, 8'd0, 8'd255}); // R3 R4 R5 mixed, R6
    send({8'd100, 8'd1, 8'd127}, {8'd255, 8'd254, 8'd128}); // R2
    send({8'd10, 8'd64, 8'd250}, {8'd200, 8'd192, 8'd5});   // R2 truncation
    idle();

    // random with stalls and gaps
    stall_mode = 1;
    for (int v = 0; v < 400; v++) begin
      logic [23:0] s, l;
      for (int c = 0; c < 3; c++) begin
        case ($urandom_range(3))
          0:       s[8*c +: 8] = 8'd0;
          1:       s[8*c +: 8] = 8'd255;
          default: s[8*c +: 8] = 8'($urandom_range(255));
        endcase
        case ($urandom_range(3))
          0:       l[8*c +: 8] = 8'd0;
          1:       l[8*c +: 8] = 8'd255;
          default: l[8*c +: 8] = 8'($urandom_range(255));
        endcase
      end
      send(s, l);
      if ($urandom_range(7) == 0) idle();
    end
    idle();
    while (sb_q.size() != 0) idle();
    stall_mode = 0;
    repeat (4) idle();
    chk(!out_valid, "R7", "drained", out_valid, 0);
    summary();
    $finish;
  end
endmodule